// File: doc/BRIEF.md
# Edge-Detect Interrupt Capture Unit

This block watches the lower three 8-line ports of a digital I/O bank for signal transitions. Each watched line has its own edge-select bit and its own arm bit. When an armed line makes the chosen transition, the block records it in a sticky per-line capture bit. The capture bits are grouped into one byte per port.

Each port gets a summary bit that is set while any capture bit in that port is set. A single level interrupt output is asserted while any summary bit is set. The host acknowledges a port by writing zero to that port's capture byte. The line levels arriving here are already synchronized. The edge-select and arm settings come from the register bank, and so do the per-port acknowledge writes.

Top module: `edge_irq_capture`

## Requirements
- R1: While reset is high, every capture bit, every summary bit and the interrupt output are 0.
- R2: A line whose edge-select bit is 1 and whose arm bit is 1 captures a rising edge (level 0 in one cycle, 1 in the next). Its capture bit (bit 8p+i of the capture bus, for port p and line i) reads 1 right after the clock edge that samples the new level.
- R3: A line whose edge-select bit is 0 captures only falling edges. A transition in the other direction leaves its capture bit unchanged.
- R4: A line whose arm bit is 0 captures nothing. The previous-level register keeps following the line while it is disarmed, so arming a line whose level has already settled does not produce a capture.
- R5: A capture bit stays at 1 until an acknowledge clears its port, whatever the line does afterwards.
- R6: An acknowledge write with data zero and strobe bit p set clears every capture bit of port p and leaves the other ports unchanged. An acknowledge write with nonzero data has no effect.
- R7: When a new edge and a zero acknowledge hit the same port in the same cycle, the new edge's bit is 1 afterwards and the port's other bits are cleared.
- R8: Changing an edge-select bit while the line level is steady does not produce a capture.
- R9: Summary bit p is the OR of the eight capture bits of port p, for p from 0 to 2.
- R10: The interrupt output is 1 exactly when at least one summary bit is 1.
- R11: In the first clock after reset is released, no line captures, whatever its level, because there is not yet a previous level to compare against.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_lvl | input | 24 | Synchronized levels of the watched lines, port p in bits 8p+7..8p |
| edge_sel | input | 24 | Per-line edge select: 1 = rising, 0 = falling |
| arm | input | 24 | Per-line capture enable |
| ack_we | input | 3 | Per-port acknowledge write strobe |
| ack_data | input | 8 | Data of the acknowledge write; only zero clears |
| cap_bits | output | 24 | Sticky capture bits, one byte per port |
| pending | output | 3 | Per-port summary of the capture bits |
| irq | output | 1 | Level interrupt, high while any summary bit is set |

## Verification
Two internal faults are the ones to worry about. The first is a stale or mis-reset previous-level register. The second is a clear that is decoded wrongly. Either one changes the capture bus one clock after the stimulus, and through the summary bits it also changes the interrupt line in that same cycle. So each cycle's stimulus is compared against an independent model at the following edge. The first cycle after reset, a polarity flip on a steady line, and an edge that arrives together with an acknowledge are the cases where a phantom or lost capture would show up at the ports at once.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;

    localparam int DEF_LINES_PER_PORT = 8;
    localparam int DEF_NUM_PORTS      = 3;

    typedef enum logic {
        ID_KEEP = 1'b0,
        ID_WIPE = 1'b1
    } id_op_e;

    typedef struct packed {
        logic we;
        logic data_zero;
    } ack_req_t;

    function automatic id_op_e decode_ack(ack_req_t req);
        return (req.we && req.data_zero) ? ID_WIPE : ID_KEEP;
    endfunction

endpackage

// File: rtl/edge_cap_level_track.sv
module edge_cap_level_track #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall,
    output logic             hist_vld
);
    logic [WIDTH-1:0] prev_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            prev_q <= lvl;
            vld_q  <= 1'b1;
        end
    end

    always_comb begin
        rise     = lvl & ~prev_q;
        fall     = ~lvl & prev_q;
        hist_vld = vld_q;
    end
endmodule

// File: rtl/edge_cap_port_latch.sv
module edge_cap_port_latch
    import edge_cap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] arm,
    input  logic         hist_vld,
    input  id_op_e       op,
    output logic [W-1:0] id
);
    logic [W-1:0] hit;
    logic [W-1:0] base;

    always_comb begin
        hit  = {W{hist_vld}} & arm & ((sel & rise) | (~sel & fall));
        base = (op == ID_WIPE) ? '0 : id;
    end

    always_ff @(posedge clk) begin
        if (rst) id <= '0;
        else     id <= base | hit;
    end
endmodule

// File: rtl/edge_cap_summary.sv
module edge_cap_summary #(
    parameter int W  = 8,
    parameter int NP = 3
) (
    input  logic [W*NP-1:0] id_flat,
    output logic [NP-1:0]   pending,
    output logic            irq
);
    for (genvar p = 0; p < NP; p++) begin : g_or
        assign pending[p] = |id_flat[p*W +: W];
    end
    assign irq = |pending;
endmodule

// File: rtl/edge_irq_capture.sv
module edge_irq_capture
    import edge_cap_pkg::*;
#(
    parameter int LINES_PER_PORT = DEF_LINES_PER_PORT,
    parameter int NUM_PORTS      = DEF_NUM_PORTS
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [LINES_PER_PORT*NUM_PORTS-1:0] line_lvl,
    input  logic [LINES_PER_PORT*NUM_PORTS-1:0] edge_sel,
    input  logic [LINES_PER_PORT*NUM_PORTS-1:0] arm,
    input  logic [NUM_PORTS-1:0]                ack_we,
    input  logic [LINES_PER_PORT-1:0]           ack_data,
    output logic [LINES_PER_PORT*NUM_PORTS-1:0] cap_bits,
    output logic [NUM_PORTS-1:0]                pending,
    output logic                                irq
);
    localparam int TOTAL = LINES_PER_PORT * NUM_PORTS;

    logic [TOTAL-1:0] rise;
    logic [TOTAL-1:0] fall;
    logic             hist_vld;
    logic             data_zero;

    assign data_zero = (ack_data == '0);

    edge_cap_level_track #(.WIDTH(TOTAL)) u_track (
        .clk      (clk),
        .rst      (rst),
        .lvl      (line_lvl),
        .rise     (rise),
        .fall     (fall),
        .hist_vld (hist_vld)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ack_req_t req;
        id_op_e   op;
        always_comb begin
            req.we        = ack_we[p];
            req.data_zero = data_zero;
            op            = decode_ack(req);
        end
        edge_cap_port_latch #(.W(LINES_PER_PORT)) u_latch (
            .clk      (clk),
            .rst      (rst),
            .rise     (rise[p*LINES_PER_PORT +: LINES_PER_PORT]),
            .fall     (fall[p*LINES_PER_PORT +: LINES_PER_PORT]),
            .sel      (edge_sel[p*LINES_PER_PORT +: LINES_PER_PORT]),
            .arm      (arm[p*LINES_PER_PORT +: LINES_PER_PORT]),
            .hist_vld (hist_vld),
            .op       (op),
            .id       (cap_bits[p*LINES_PER_PORT +: LINES_PER_PORT])
        );
    end

    edge_cap_summary #(.W(LINES_PER_PORT), .NP(NUM_PORTS)) u_sum (
        .id_flat (cap_bits),
        .pending (pending),
        .irq     (irq)
    );
endmodule

// File: rtl/edge_irq_capture_chk.sv
module edge_irq_capture_chk #(
    parameter int LINES_PER_PORT = 8,
    parameter int NUM_PORTS      = 3
) (
    input logic                                clk,
    input logic                                rst,
    input logic [LINES_PER_PORT*NUM_PORTS-1:0] line_lvl,
    input logic [LINES_PER_PORT*NUM_PORTS-1:0] arm,
    input logic [NUM_PORTS-1:0]                ack_we,
    input logic [LINES_PER_PORT-1:0]           ack_data,
    input logic [LINES_PER_PORT*NUM_PORTS-1:0] cap_bits,
    input logic [NUM_PORTS-1:0]                pending,
    input logic                                irq
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (cap_bits == '0));

    assert_disarmed_no_capture_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((cap_bits & ~$past(cap_bits) & ~$past(arm)) == '0));

    assert_first_cycle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (cap_bits == '0));

    assert_irq_summary_R10: assert property (@(posedge clk) disable iff (rst)
        irq == (pending != '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
            !(ack_we[p] && ack_data == '0) |=>
            ((cap_bits[p*LINES_PER_PORT +: LINES_PER_PORT] &
              $past(cap_bits[p*LINES_PER_PORT +: LINES_PER_PORT])) ==
             $past(cap_bits[p*LINES_PER_PORT +: LINES_PER_PORT])));

        assert_pending_or_R9: assert property (@(posedge clk) disable iff (rst)
            pending[p] == (cap_bits[p*LINES_PER_PORT +: LINES_PER_PORT] != '0));
    end
endmodule

bind edge_irq_capture edge_irq_capture_chk #(
    .LINES_PER_PORT (LINES_PER_PORT),
    .NUM_PORTS      (NUM_PORTS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .line_lvl (line_lvl),
    .arm      (arm),
    .ack_we   (ack_we),
    .ack_data (ack_data),
    .cap_bits (cap_bits),
    .pending  (pending),
    .irq      (irq)
);

// File: tb/sim_edge_irq_capture.sv
module sim_edge_irq_capture;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int NP = 3;
    localparam int T  = W * NP;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [T-1:0]  line_lvl = '1;
    logic [T-1:0]  edge_sel = '1;
    logic [T-1:0]  arm      = '1;
    logic [NP-1:0] ack_we   = '0;
    logic [W-1:0]  ack_data = '0;
    logic [T-1:0]  cap_bits;
    logic [NP-1:0] pending;
    logic          irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    typedef struct {
        logic [T-1:0] id;
        string        tag;
    } exp_t;
    exp_t q[$];

    logic [T-1:0] m_prev = '0;
    logic         m_vld  = 1'b0;
    logic [T-1:0] m_id   = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_irq_capture u0 (
        .clk(clk), .rst(rst), .line_lvl(line_lvl), .edge_sel(edge_sel),
        .arm(arm), .ack_we(ack_we), .ack_data(ack_data),
        .cap_bits(cap_bits), .pending(pending), .irq(irq)
    );

    function automatic logic [NP-1:0] exp_pend(logic [T-1:0] id);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = |id[p*W +: W];
        return r;
    endfunction

    task automatic compare(logic [T-1:0] exp_id, string tag);
        logic [NP-1:0] ep;
        ep = exp_pend(exp_id);
        vectors++;
        if (cap_bits !== exp_id) begin
            miscompares++;
            $display("FAIL %s cap_bits actual=%h expected=%h", tag, cap_bits, exp_id);
        end else if (pending !== ep) begin
            miscompares++;
            $display("FAIL %s/R9 pending actual=%b expected=%b", tag, pending, ep);
        end else if (irq !== (ep != '0)) begin
            miscompares++;
            $display("FAIL %s/R10 irq actual=%b expected=%b", tag, irq, (ep != '0));
        end
    endtask

    // driver: called at a falling edge; applies inputs, predicts the next state
    task automatic step(logic [T-1:0] lvl, logic [T-1:0] sel, logic [T-1:0] en,
                        logic [NP-1:0] we, logic [W-1:0] data, string tag);
        logic [T-1:0] hit;
        exp_t e;
        line_lvl = lvl; edge_sel = sel; arm = en; ack_we = we; ack_data = data;
        hit = {T{m_vld}} & en & ((sel & lvl & ~m_prev) | (~sel & ~lvl & m_prev));
        for (int p = 0; p < NP; p++)
            if (we[p] && data == '0) m_id[p*W +: W] = '0;
        m_id   = m_id | hit;
        m_prev = lvl;
        m_vld  = 1'b1;
        e.id = m_id; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                compare(e.id, e.tag);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare('0, "R1");
        rst = 1'b0;
        step(24'hFFFFFF, '1, '1, 3'b000, 8'h00, "R11");
        step(24'hFFFFFE, '1, '1, 3'b000, 8'h00, "R3");
        step(24'hFFFFFF, '1, '1, 3'b000, 8'h00, "R2");
        step(24'hFFFFFF, '0, '1, 3'b000, 8'h00, "R8");
        step(24'hFF00FF, '0, '1, 3'b000, 8'h00, "R3");
        step(24'hFFFFFF, '0, '1, 3'b000, 8'h00, "R5");
        step(24'hFFFFFF, '0, '1, 3'b010, 8'h5A, "R6");
        step(24'hFFFFFF, '0, '1, 3'b010, 8'h00, "R6");
        step(24'h00FFFF, '0, '0, 3'b000, 8'h00, "R4");
        step(24'h00FFFF, '0, '1, 3'b000, 8'h00, "R4");
        step(24'h00FFFD, '0, '1, 3'b001, 8'h00, "R7");
        step(24'h00FFFD, '0, '1, 3'b111, 8'h00, "R6");
        ack_we = '0;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule